// File: doc/BRIEF.md
# Register rename mapping table

This block keeps two logical-to-physical maps for a 32-entry integer register file. The speculative map is updated by the rename stage and read by many source-operand lookups. The architectural map is updated by retiring instructions. Each read port is registered. It returns the speculative mapping one cycle after its address is presented. A rename write to the same address in the same cycle is forwarded to the read, and a hold input freezes the port's result.

Each retire lane reports the physical register that its write displaces from the architectural map. One cycle later it reports whether that register may go back to the free pool. A register is not freed if it is still named by another architectural entry. This happens when a move is eliminated and two logical registers share one physical register. A register is also not freed if a lower-numbered lane already reported it. On a redirect, the speculative map is rebuilt one cycle later. It is rebuilt either from the architectural map or from a snapshot image supplied from outside.

Top module: `rename_map_table`

## Requirements
- R1: A read address presented in cycle T returns the speculative entry at that address in cycle T+1.
- R2: If an enabled speculative write lane targets the read address in cycle T, the read returns that lane's data in T+1. When several lanes match, the highest-numbered lane supplies the data.
- R3: When a read port's hold is high in cycle T, its output in T+1 equals its output in T.
- R4: A speculative write changes the table only when its enable is high. When several lanes write one address in the same cycle, the highest-numbered lane's data is stored.
- R5: After a redirect arrives with use-snapshot low in cycle T, the speculative table at the end of T+1 is overwritten with the architectural table as it stood during T+1. Speculative writes in T+1 are discarded and not forwarded.
- R6: After a redirect arrives with use-snapshot high in cycle T, the speculative table is overwritten at the end of T+1 with the snapshot image presented in T+1. Entry i occupies bits [8i+7:8i]. Speculative writes in T+1 are discarded and not forwarded.
- R7: Architectural writes take effect only when enabled, and the highest-numbered lane wins on a shared address. Lane n's displaced output in T+1 is 0 if its enable was low in T. Otherwise it is the architectural entry at its address during T.
- R8: If lower-numbered enabled lanes write the same architectural address as lane n in cycle T, lane n's displaced output in T+1 is the data of the highest such lane.
- R9: Lane n's free flag in T+2 is high only when all of the following hold. Lane n was enabled in T. The displaced value it shows in T+1 matches no architectural entry during T+1. No lower enabled lane shows the same displaced value in T+1.
- R10: Synchronous reset sets both tables so that logical register i maps to physical register i. Reset also clears all read outputs, displaced outputs and free flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 12x5 | Read port logical addresses |
| rd_hold | input | 12 | Per-port hold of the previous result |
| rd_data | output | 12x8 | Registered read results |
| spec_we | input | 6 | Speculative write enables |
| spec_addr | input | 6x5 | Speculative write addresses |
| spec_data | input | 6x8 | Speculative write physical registers |
| arch_we | input | 6 | Architectural write enables |
| arch_addr | input | 6x5 | Architectural write addresses |
| arch_data | input | 6x8 | Architectural write physical registers |
| redir_valid | input | 1 | Redirect arrives this cycle |
| redir_use_snap | input | 1 | Redirect restores from the snapshot image |
| snap_image | input | 256 | Snapshot image, sampled in the cycle after the redirect |
| old_preg | output | 6x8 | Displaced physical register per retire lane |
| free_ok | output | 6 | Displaced register may be freed |

## Verification
A corrupted speculative entry is not visible until a read port addresses it. It then appears one cycle later on rd_data. The bench therefore sweeps every address after each redirect and keeps random reads running throughout. A corrupted architectural entry shows up in two ways. It appears on old_preg one cycle after a retire write hits that address. It also appears as a wrong speculative image one cycle after the next architectural reload. A stale or missing copy of a shared physical register changes free_ok two cycles after the retire write. For that reason, retire data is drawn from a narrow range so that sharing occurs often.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
    localparam int RMT_LREGS      = 32;
    localparam int RMT_PREG_W     = 8;
    localparam int RMT_READS      = 12;
    localparam int RMT_SPEC_LANES = 6;
    localparam int RMT_ARCH_LANES = 6;

    // source of a speculative-table rebuild
    typedef enum logic {
        SRC_ARCH = 1'b0,
        SRC_SNAP = 1'b1
    } reload_src_e;

    // redirect request delayed by one cycle before it is acted on
    typedef struct packed {
        logic        act;
        reload_src_e src;
    } reload_req_t;
endpackage

// File: rtl/rmt_tables.sv
module rmt_tables
    import rmt_pkg::*;
#(
    parameter int LREGS      = RMT_LREGS,
    parameter int PREG_W     = RMT_PREG_W,
    parameter int SPEC_LANES = RMT_SPEC_LANES,
    parameter int ARCH_LANES = RMT_ARCH_LANES
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   redir_valid,
    input  logic                                   redir_use_snap,
    input  logic [LREGS*PREG_W-1:0]                snap_image,
    input  logic [SPEC_LANES-1:0]                  spec_we,
    input  logic [SPEC_LANES-1:0][$clog2(LREGS)-1:0] spec_addr,
    input  logic [SPEC_LANES-1:0][PREG_W-1:0]      spec_data,
    input  logic [ARCH_LANES-1:0]                  arch_we,
    input  logic [ARCH_LANES-1:0][$clog2(LREGS)-1:0] arch_addr,
    input  logic [ARCH_LANES-1:0][PREG_W-1:0]      arch_data,
    output logic [LREGS-1:0][PREG_W-1:0]           spec_tab,
    output logic [LREGS-1:0][PREG_W-1:0]           arch_tab,
    output logic [SPEC_LANES-1:0]                  spec_we_eff
);
    reload_req_t                   req_q;
    logic [LREGS-1:0][PREG_W-1:0]  spec_q;
    logic [LREGS-1:0][PREG_W-1:0]  arch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{act: 1'b0, src: SRC_ARCH};
        end else begin
            req_q <= '{act: redir_valid, src: (redir_use_snap ? SRC_SNAP : SRC_ARCH)};
        end
    end

    // rename writes are dropped in the rebuild cycle
    assign spec_we_eff = req_q.act ? '0 : spec_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LREGS; i++) spec_q[i] <= PREG_W'(i);
        end else if (req_q.act) begin
            if (req_q.src == SRC_SNAP) spec_q <= snap_image;
            else                       spec_q <= arch_q;
        end else begin
            // ascending order: the highest enabled lane is assigned last
            for (int l = 0; l < SPEC_LANES; l++)
                if (spec_we[l]) spec_q[spec_addr[l]] <= spec_data[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LREGS; i++) arch_q[i] <= PREG_W'(i);
        end else begin
            for (int l = 0; l < ARCH_LANES; l++)
                if (arch_we[l]) arch_q[arch_addr[l]] <= arch_data[l];
        end
    end

    assign spec_tab = spec_q;
    assign arch_tab = arch_q;

    // R5: rebuild from the architectural table
    p_reload_arch_r5: assert property (@(posedge clk) disable iff (rst)
        (req_q.act && req_q.src == SRC_ARCH) |=> (spec_q == $past(arch_q)));

    // R6: rebuild from the snapshot image
    p_reload_snap_r6: assert property (@(posedge clk) disable iff (rst)
        (req_q.act && req_q.src == SRC_SNAP) |=> (spec_q == $past(snap_image)));
endmodule

// File: rtl/rmt_read_port.sv
module rmt_read_port
    import rmt_pkg::*;
#(
    parameter int LREGS      = RMT_LREGS,
    parameter int PREG_W     = RMT_PREG_W,
    parameter int SPEC_LANES = RMT_SPEC_LANES
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [$clog2(LREGS)-1:0]                 addr,
    input  logic                                     hold,
    input  logic [LREGS-1:0][PREG_W-1:0]             spec_tab,
    input  logic [SPEC_LANES-1:0]                    wr_en,
    input  logic [SPEC_LANES-1:0][$clog2(LREGS)-1:0] wr_addr,
    input  logic [SPEC_LANES-1:0][PREG_W-1:0]        wr_data,
    output logic [PREG_W-1:0]                        rd_data
);
    logic [PREG_W-1:0] pick;
    logic [PREG_W-1:0] rd_q;

    always_comb begin
        pick = spec_tab[addr];
        for (int l = 0; l < SPEC_LANES; l++)
            if (wr_en[l] && wr_addr[l] == addr) pick = wr_data[l];
    end

    always_ff @(posedge clk) begin
        if (rst)       rd_q <= '0;
        else if (!hold) rd_q <= pick;
    end

    assign rd_data = rd_q;

    // R3: a held port repeats its result
    p_hold_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(rd_q));

    // R2: the top lane's write is forwarded to a matching read
    p_fwd_top_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (!hold && wr_en[SPEC_LANES-1] && wr_addr[SPEC_LANES-1] == addr)
        |=> (rd_q == $past(wr_data[SPEC_LANES-1])));
endmodule

// File: rtl/rmt_release.sv
module rmt_release
    import rmt_pkg::*;
#(
    parameter int LREGS      = RMT_LREGS,
    parameter int PREG_W     = RMT_PREG_W,
    parameter int ARCH_LANES = RMT_ARCH_LANES
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [LREGS-1:0][PREG_W-1:0]             arch_tab,
    input  logic [ARCH_LANES-1:0]                    we,
    input  logic [ARCH_LANES-1:0][$clog2(LREGS)-1:0] addr,
    input  logic [ARCH_LANES-1:0][PREG_W-1:0]        data,
    output logic [ARCH_LANES-1:0][PREG_W-1:0]        old_preg,
    output logic [ARCH_LANES-1:0]                    free_ok
);
    logic [ARCH_LANES-1:0][PREG_W-1:0] disp;
    logic [ARCH_LANES-1:0][PREG_W-1:0] old_q;
    logic [ARCH_LANES-1:0]             vld_q;
    logic [ARCH_LANES-1:0]             free_q;
    logic [ARCH_LANES-1:0]             keep;

    // stage 1: displaced value with bypass from lower lanes
    always_comb begin
        for (int n = 0; n < ARCH_LANES; n++) begin
            disp[n] = arch_tab[addr[n]];
            for (int j = 0; j < ARCH_LANES; j++)
                if (j < n && we[j] && addr[j] == addr[n]) disp[n] = data[j];
        end
    end

    // stage 2: a displaced register is kept if still mapped or already reported
    always_comb begin
        for (int n = 0; n < ARCH_LANES; n++) begin
            keep[n] = 1'b0;
            for (int i = 0; i < LREGS; i++)
                if (arch_tab[i] == old_q[n]) keep[n] = 1'b1;
            for (int j = 0; j < ARCH_LANES; j++)
                if (j < n && vld_q[j] && old_q[j] == old_q[n]) keep[n] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            old_q  <= '0;
            vld_q  <= '0;
            free_q <= '0;
        end else begin
            for (int n = 0; n < ARCH_LANES; n++)
                old_q[n] <= we[n] ? disp[n] : '0;
            vld_q  <= we;
            free_q <= vld_q & ~keep;
        end
    end

    assign old_preg = old_q;
    assign free_ok  = free_q;

    for (genvar n = 0; n < ARCH_LANES; n++) begin : g_lane_chk
        // R7: an idle lane reports zero
        p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
            !we[n] |=> (old_q[n] == '0));
        if (n > 0) begin : g_byp
            // R8: the adjacent lower lane bypasses on a shared address
            p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
                (we[n] && we[n-1] && addr[n] == addr[n-1])
                |=> (old_q[n] == $past(data[n-1])));
        end
        for (genvar j = 0; j < n; j++) begin : g_pair
            // R9: no two lanes free the same register in one cycle
            p_free_unique_r9: assert property (@(posedge clk) disable iff (rst)
                (free_q[n] && free_q[j]) |-> ($past(old_q[n]) != $past(old_q[j])));
        end
    end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
    import rmt_pkg::*;
#(
    parameter int LREGS      = RMT_LREGS,
    parameter int PREG_W     = RMT_PREG_W,
    parameter int READS      = RMT_READS,
    parameter int SPEC_LANES = RMT_SPEC_LANES,
    parameter int ARCH_LANES = RMT_ARCH_LANES,
    localparam int LREG_W    = $clog2(LREGS)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [READS-1:0][LREG_W-1:0]        rd_addr,
    input  logic [READS-1:0]                    rd_hold,
    output logic [READS-1:0][PREG_W-1:0]        rd_data,
    input  logic [SPEC_LANES-1:0]               spec_we,
    input  logic [SPEC_LANES-1:0][LREG_W-1:0]   spec_addr,
    input  logic [SPEC_LANES-1:0][PREG_W-1:0]   spec_data,
    input  logic [ARCH_LANES-1:0]               arch_we,
    input  logic [ARCH_LANES-1:0][LREG_W-1:0]   arch_addr,
    input  logic [ARCH_LANES-1:0][PREG_W-1:0]   arch_data,
    input  logic                                redir_valid,
    input  logic                                redir_use_snap,
    input  logic [LREGS*PREG_W-1:0]             snap_image,
    output logic [ARCH_LANES-1:0][PREG_W-1:0]   old_preg,
    output logic [ARCH_LANES-1:0]               free_ok
);
    logic [LREGS-1:0][PREG_W-1:0] spec_tab;
    logic [LREGS-1:0][PREG_W-1:0] arch_tab;
    logic [SPEC_LANES-1:0]        spec_we_eff;

    rmt_tables #(
        .LREGS(LREGS), .PREG_W(PREG_W),
        .SPEC_LANES(SPEC_LANES), .ARCH_LANES(ARCH_LANES)
    ) u_tables (
        .clk(clk), .rst(rst),
        .redir_valid(redir_valid), .redir_use_snap(redir_use_snap),
        .snap_image(snap_image),
        .spec_we(spec_we), .spec_addr(spec_addr), .spec_data(spec_data),
        .arch_we(arch_we), .arch_addr(arch_addr), .arch_data(arch_data),
        .spec_tab(spec_tab), .arch_tab(arch_tab), .spec_we_eff(spec_we_eff)
    );

    for (genvar p = 0; p < READS; p++) begin : g_rd
        rmt_read_port #(
            .LREGS(LREGS), .PREG_W(PREG_W), .SPEC_LANES(SPEC_LANES)
        ) u_port (
            .clk(clk), .rst(rst),
            .addr(rd_addr[p]), .hold(rd_hold[p]),
            .spec_tab(spec_tab),
            .wr_en(spec_we_eff), .wr_addr(spec_addr), .wr_data(spec_data),
            .rd_data(rd_data[p])
        );
    end

    rmt_release #(
        .LREGS(LREGS), .PREG_W(PREG_W), .ARCH_LANES(ARCH_LANES)
    ) u_release (
        .clk(clk), .rst(rst),
        .arch_tab(arch_tab),
        .we(arch_we), .addr(arch_addr), .data(arch_data),
        .old_preg(old_preg), .free_ok(free_ok)
    );
endmodule

// File: tb/rename_map_table_bench.sv
module rename_map_table_bench;
    localparam int NL = 32;
    localparam int NR = 12;
    localparam int NS = 6;
    localparam int NA = 6;

    logic clk = 1'b0;
    logic rst;
    logic [NR-1:0][4:0] rd_addr;
    logic [NR-1:0]      rd_hold;
    logic [NR-1:0][7:0] rd_data;
    logic [NS-1:0]      spec_we;
    logic [NS-1:0][4:0] spec_addr;
    logic [NS-1:0][7:0] spec_data;
    logic [NA-1:0]      arch_we;
    logic [NA-1:0][4:0] arch_addr;
    logic [NA-1:0][7:0] arch_data;
    logic               redir_valid;
    logic               redir_use_snap;
    logic [NL*8-1:0]    snap_image;
    logic [NA-1:0][7:0] old_preg;
    logic [NA-1:0]      free_ok;

    always #4 clk = ~clk;

    rename_map_table u_rename_map_table (
        .clk(clk), .rst(rst),
        .rd_addr(rd_addr), .rd_hold(rd_hold), .rd_data(rd_data),
        .spec_we(spec_we), .spec_addr(spec_addr), .spec_data(spec_data),
        .arch_we(arch_we), .arch_addr(arch_addr), .arch_data(arch_data),
        .redir_valid(redir_valid), .redir_use_snap(redir_use_snap),
        .snap_image(snap_image),
        .old_preg(old_preg), .free_ok(free_ok)
    );

    // behavioural reference state
    int    m_spec [NL];
    int    m_arch [NL];
    int    m_rd   [NR];
    string m_rtag [NR];
    int    m_old  [NA];
    string m_otag [NA];
    bit    m_vld  [NA];
    bit    m_free [NA];
    bit    m_act, m_snap;
    string phase_tag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic model_update();
        int nrd[NR]; int nold[NA]; bit nvld[NA]; bit nfree[NA];
        int nspec[NL]; string t;
        if (rst) begin
            for (int i = 0; i < NL; i++) begin m_spec[i] = i; m_arch[i] = i; end
            for (int p = 0; p < NR; p++) begin m_rd[p] = 0; m_rtag[p] = "R10"; end
            for (int n = 0; n < NA; n++) begin
                m_old[n] = 0; m_vld[n] = 0; m_free[n] = 0; m_otag[n] = "R10";
            end
            m_act = 0; m_snap = 0;
            return;
        end
        for (int n = 0; n < NA; n++) begin
            nfree[n] = m_vld[n];
            for (int i = 0; i < NL; i++) if (m_arch[i] == m_old[n]) nfree[n] = 0;
            for (int j = 0; j < n; j++) if (m_vld[j] && m_old[j] == m_old[n]) nfree[n] = 0;
        end
        for (int n = 0; n < NA; n++) begin
            if (arch_we[n]) begin
                nold[n] = m_arch[arch_addr[n]]; m_otag[n] = "R7";
                for (int j = 0; j < n; j++)
                    if (arch_we[j] && arch_addr[j] == arch_addr[n]) begin
                        nold[n] = arch_data[j]; m_otag[n] = "R8";
                    end
                nvld[n] = 1;
            end else begin
                nold[n] = 0; nvld[n] = 0; m_otag[n] = "R7";
            end
        end
        for (int p = 0; p < NR; p++) begin
            if (rd_hold[p]) begin
                nrd[p] = m_rd[p]; t = "R3";
            end else begin
                nrd[p] = m_spec[rd_addr[p]]; t = "R1";
                if (!m_act)
                    for (int l = 0; l < NS; l++)
                        if (spec_we[l] && spec_addr[l] == rd_addr[p]) begin
                            nrd[p] = spec_data[l]; t = "R2";
                        end
            end
            m_rtag[p] = (phase_tag != "") ? phase_tag : t;
        end
        for (int i = 0; i < NL; i++) nspec[i] = m_spec[i];
        if (m_act) begin
            for (int i = 0; i < NL; i++)
                nspec[i] = m_snap ? int'(snap_image[i*8 +: 8]) : m_arch[i];
        end else begin
            for (int l = 0; l < NS; l++) if (spec_we[l]) nspec[spec_addr[l]] = spec_data[l];
        end
        for (int l = 0; l < NA; l++) if (arch_we[l]) m_arch[arch_addr[l]] = arch_data[l];
        for (int i = 0; i < NL; i++) m_spec[i] = nspec[i];
        for (int p = 0; p < NR; p++) m_rd[p] = nrd[p];
        for (int n = 0; n < NA; n++) begin
            m_old[n] = nold[n]; m_vld[n] = nvld[n]; m_free[n] = nfree[n];
        end
        m_act = redir_valid; m_snap = redir_use_snap;
    endtask

    task automatic compare();
        for (int p = 0; p < NR; p++) begin
            n_cmp++;
            if (int'(rd_data[p]) != m_rd[p]) begin
                n_bad++;
                $display("FAIL %s rd_data[%0d] actual %0d expected %0d", m_rtag[p], p, rd_data[p], m_rd[p]);
            end
        end
        for (int n = 0; n < NA; n++) begin
            n_cmp++;
            if (int'(old_preg[n]) != m_old[n]) begin
                n_bad++;
                $display("FAIL %s old_preg[%0d] actual %0d expected %0d", m_otag[n], n, old_preg[n], m_old[n]);
            end
            n_cmp++;
            if (free_ok[n] != m_free[n]) begin
                n_bad++;
                $display("FAIL %s free_ok[%0d] actual %0d expected %0d",
                         (rst ? "R10" : "R9"), n, free_ok[n], m_free[n]);
            end
        end
    endtask

    task automatic step();
        model_update();
        @(negedge clk);
        if (!done) compare();
    endtask

    task automatic idle_inputs();
        rd_hold = '0; spec_we = '0; arch_we = '0;
        redir_valid = 0; redir_use_snap = 0;
        for (int p = 0; p < NR; p++) rd_addr[p] = 5'(p);
        for (int l = 0; l < NS; l++) begin spec_addr[l] = '0; spec_data[l] = '0; end
        for (int l = 0; l < NA; l++) begin arch_addr[l] = '0; arch_data[l] = '0; end
    endtask

    task automatic rand_inputs(int span, int sp, int ap, int hp, int dspan);
        for (int p = 0; p < NR; p++) begin
            rd_addr[p] = 5'($urandom % span);
            rd_hold[p] = ($urandom % 100) < hp;
        end
        for (int l = 0; l < NS; l++) begin
            spec_we[l]   = ($urandom % 100) < sp;
            spec_addr[l] = 5'($urandom % span);
            spec_data[l] = 8'($urandom % 256);
        end
        for (int l = 0; l < NA; l++) begin
            arch_we[l]   = ($urandom % 100) < ap;
            arch_addr[l] = 5'($urandom % span);
            arch_data[l] = 8'($urandom % dspan);
        end
    endtask

    task automatic sweep_reads();
        rand_inputs(32, 0, 0, 0, 48);
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < NR; p++) rd_addr[p] = 5'((k * NR + p) % NL);
            step();
        end
    endtask

    task automatic redirect_case(bit use_snap);
        rand_inputs(32, 50, 30, 0, 64);
        redir_valid = 1; redir_use_snap = use_snap;
        step();
        rand_inputs(32, 80, 30, 0, 64);
        redir_valid = 0;
        for (int i = 0; i < NL; i++) snap_image[i*8 +: 8] = 8'($urandom);
        step();
        sweep_reads();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        phase_tag = "R10";
        snap_image = '0;
        idle_inputs();
        rst = 1;
        @(negedge clk);
        repeat (3) step();
        rst = 0;
        // R10: identity mapping after reset
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < NR; p++) rd_addr[p] = 5'((k * NR + p) % NL);
            step();
        end
        step();

        // R1 R2 R3 R7 R8 R9: random traffic with narrow address ranges
        phase_tag = "";
        repeat (400) begin rand_inputs(8, 40, 40, 20, 40); step(); end

        // R4: all rename lanes hit one address, then read it back
        phase_tag = "R4";
        repeat (20) begin
            rand_inputs(32, 0, 0, 0, 40);
            spec_we = '1;
            begin
                logic [4:0] a = 5'($urandom);
                for (int l = 0; l < NS; l++) spec_addr[l] = a;
                for (int p = 0; p < NR; p++) rd_addr[p] = a;
                step();
                spec_we = '0;
                step();
            end
        end

        // R5 and R6: rebuild from the architectural table or a snapshot
        phase_tag = "R5";
        repeat (10) redirect_case(1'b0);
        phase_tag = "R6";
        repeat (10) redirect_case(1'b1);

        // R8: every retire lane writes one address
        phase_tag = "";
        repeat (40) begin
            rand_inputs(32, 20, 100, 10, 40);
            for (int l = 1; l < NA; l++) arch_addr[l] = arch_addr[0];
            step();
        end
        // R9: retire lanes share data (eliminated moves)
        repeat (60) begin
            rand_inputs(32, 20, 80, 10, 6);
            step();
        end

        // mixed traffic with occasional redirects
        repeat (1500) begin
            rand_inputs(16, 50, 50, 15, 48);
            redir_valid = ($urandom % 100) < 5;
            redir_use_snap = $urandom % 2;
            for (int i = 0; i < NL; i++) snap_image[i*8 +: 8] = 8'($urandom);
            step();
        end
        idle_inputs();
        step();
        step();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule